// File: doc/BRIEF.md
# TDMA Slot Window Timer

This block keeps the time base of one node on a time-triggered broadcast bus and derives, for whichever slot is current, three nested timing windows: the receiver acceptance window, the bus guardian gate and the transmitter enable. A local time counter runs from zero to a programmable round length and wraps. A small schedule table gives each slot a start time, a maximum transmission duration and a flag that marks the slots this node may send in. All window edges are measured from the slot start and scaled by a programmable precision value P, which bounds the clock skew between nodes.

Frames carry no addresses, so the index of the current slot is the only identity of the sender and is output as such. The guardian gate stands between the node's transmit request and the bus line. Outside the gate the line is held low, blocked cycles are counted, and a transmitter that is still requesting when its gate closes is flagged as babbling until reset. Every output comes from a register and changes only on a clock edge.

Top module: `tdma_slot_window_timer`

## Requirements
- R1: After reset the local time is 0, the slot index is 0, every window and the transmit line are low, the babble flag is low and the violation count is 0; afterwards the local time goes up by one on each clock and goes from round length minus one back to 0.
- R2: The slot index becomes k (k below the used-slot count) on the cycle the local time equals the start time of entry k, when k is the entry after the current one; it returns to 0 whenever the local time wraps to 0.
- R3: With rel the local time minus the current slot's start, d its duration, the receive window is high exactly when rel lies in [0, d+4P).
- R4: The guardian gate is high exactly when the current slot is marked as owned and rel lies in [P, d+3P).
- R5: The transmitter enable is high exactly when the current slot is owned and rel lies in [2P, 2P+d).
- R6: The transmit line in a cycle equals the transmit request sampled at that cycle's starting edge AND the guardian gate of that cycle; a request held high without pause never reaches the line outside the gate.
- R7: The violation count goes up by one for every edge at which the request is high and the new gate is low, and stops at its all-ones value.
- R8: The babble flag is set on an edge at which the request is high, the gate was open before the edge and is closed after it; it then stays high until reset.
- R9: A schedule entry write (index, start, duration, owned flag) is accepted at any edge, including during reset, and is used from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_round_len | input | TW | Cycles per round |
| cfg_prec | input | PW | Precision P in cycles |
| cfg_nslots | input | SCW | Number of used schedule entries |
| tbl_we | input | 1 | Schedule entry write strobe |
| tbl_idx | input | IW | Entry written |
| tbl_start | input | TW | Slot start time |
| tbl_dur | input | TW | Maximum transmission duration |
| tbl_own | input | 1 | Slot belongs to this node |
| tx_req | input | 1 | Transmit request from the controller |
| local_time | output | TW | Round-relative local time |
| slot_id | output | IW | Current slot, i.e. sender identity |
| rx_win | output | 1 | Receiver acceptance window |
| gate_open | output | 1 | Guardian gate |
| tx_en | output | 1 | Transmitter enable |
| tx_line | output | 1 | Gated transmit line |
| babble | output | 1 | Sticky babbling flag |
| viol_cnt | output | CW | Blocked-request count, saturating |

## Verification
The guardian closing edge is where several functions meet in one cycle: the request is cut from the line, the violation count steps and the babble flag is raised, all on the same edge. The bench provokes this by holding the request high for whole rounds, so every owned slot's gate closes under an active request, and separately by a short pulse inside the transmitter window that must end before the gate closes and raise nothing. A behavioural model computes time, slot, windows, line, count and flag each cycle from the requirements and compares every output on every clock, including the cycles where the slot change and the round wrap coincide.

// File: rtl/tdma_win_pkg.sv
package tdma_win_pkg;

    typedef struct packed {
        logic rx;
        logic gate;
        logic tx;
    } win_t;

endpackage

// File: rtl/tdma_slot_table.sv
module tdma_slot_table #(
    parameter int NS = 8,
    parameter int TW = 16,
    localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [TW-1:0] wstart,
    input  logic [TW-1:0] wdur,
    input  logic          wown,
    input  logic [IW-1:0] cur_idx,
    input  logic [IW-1:0] nxt_idx,
    output logic [TW-1:0] cur_start,
    output logic [TW-1:0] cur_dur,
    output logic          cur_own,
    output logic [TW-1:0] nxt_start
);

    logic [TW-1:0] start_q [NS];
    logic [TW-1:0] dur_q   [NS];
    logic          own_q   [NS];

    for (genvar g = 0; g < NS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (widx == IW'(g))) begin
                start_q[g] <= wstart;
                dur_q[g]   <= wdur;
                own_q[g]   <= wown;
            end
        end
    end

    always_comb begin
        cur_start = start_q[cur_idx];
        cur_dur   = dur_q[cur_idx];
        cur_own   = own_q[cur_idx];
        nxt_start = start_q[nxt_idx];
    end

endmodule

// File: rtl/tdma_win_calc.sv
module tdma_win_calc
    import tdma_win_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 8,
    localparam int EW = ((TW > PW) ? TW : PW) + 3
) (
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] start,
    input  logic [TW-1:0] dur,
    input  logic [PW-1:0] prec,
    input  logic          own,
    output win_t          win
);

    logic [EW-1:0] rel, d, p;
    logic          valid;

    always_comb begin
        valid = (now >= start);
        rel   = EW'(now) - EW'(start);
        d     = EW'(dur);
        p     = EW'(prec);
        win.rx   = valid && (rel < d + (p << 2));
        win.gate = valid && own && (rel >= p) && (rel < d + 3 * p);
        win.tx   = valid && own && (rel >= (p << 1)) && (rel < (p << 1) + d);
    end

endmodule

// File: rtl/tdma_slot_window_timer.sv
module tdma_slot_window_timer
    import tdma_win_pkg::*;
#(
    parameter int NS = 8,
    parameter int TW = 16,
    parameter int PW = 8,
    parameter int CW = 8,
    localparam int IW  = (NS > 1) ? $clog2(NS) : 1,
    localparam int SCW = $clog2(NS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cfg_round_len,
    input  logic [PW-1:0]  cfg_prec,
    input  logic [SCW-1:0] cfg_nslots,
    input  logic           tbl_we,
    input  logic [IW-1:0]  tbl_idx,
    input  logic [TW-1:0]  tbl_start,
    input  logic [TW-1:0]  tbl_dur,
    input  logic           tbl_own,
    input  logic           tx_req,
    output logic [TW-1:0]  local_time,
    output logic [IW-1:0]  slot_id,
    output logic           rx_win,
    output logic           gate_open,
    output logic           tx_en,
    output logic           tx_line,
    output logic           babble,
    output logic [CW-1:0]  viol_cnt
);

    typedef struct packed {
        logic [TW-1:0] tm;
        logic [IW-1:0] slot;
        win_t          win;
        logic          txo;
        logic          bab;
        logic [CW-1:0] viol;
    } st_t;

    st_t st_q, st_d;

    logic [TW-1:0]  time_d;
    logic [IW-1:0]  slot_d;
    logic [SCW-1:0] nxt_full;
    logic [TW:0]    tm_inc;
    logic [TW-1:0]  cur_start, cur_dur, nxt_start;
    logic           cur_own;
    win_t           win_d;

    // next time and next slot
    always_comb begin
        tm_inc   = {1'b0, st_q.tm} + 1'b1;
        time_d   = (tm_inc >= {1'b0, cfg_round_len}) ? '0 : tm_inc[TW-1:0];
        nxt_full = SCW'(st_q.slot) + 1'b1;
        if (time_d == '0)
            slot_d = '0;
        else if ((nxt_full < cfg_nslots) && (time_d == nxt_start))
            slot_d = nxt_full[IW-1:0];
        else
            slot_d = st_q.slot;
    end

    tdma_slot_table #(.NS(NS), .TW(TW)) table_i (
        .clk       (clk),
        .we        (tbl_we),
        .widx      (tbl_idx),
        .wstart    (tbl_start),
        .wdur      (tbl_dur),
        .wown      (tbl_own),
        .cur_idx   (slot_d),
        .nxt_idx   (nxt_full[IW-1:0]),
        .cur_start (cur_start),
        .cur_dur   (cur_dur),
        .cur_own   (cur_own),
        .nxt_start (nxt_start)
    );

    tdma_win_calc #(.TW(TW), .PW(PW)) calc_i (
        .now   (time_d),
        .start (cur_start),
        .dur   (cur_dur),
        .prec  (cfg_prec),
        .own   (cur_own),
        .win   (win_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tm   = time_d;
        st_d.slot = slot_d;
        st_d.win  = win_d;
        st_d.txo  = tx_req & win_d.gate;
        if (tx_req && !win_d.gate && (st_q.viol != '1))
            st_d.viol = st_q.viol + 1'b1;
        if (tx_req && st_q.win.gate && !win_d.gate)
            st_d.bab = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign local_time = st_q.tm;
    assign slot_id    = st_q.slot;
    assign rx_win     = st_q.win.rx;
    assign gate_open  = st_q.win.gate;
    assign tx_en      = st_q.win.tx;
    assign tx_line    = st_q.txo;
    assign babble     = st_q.bab;
    assign viol_cnt   = st_q.viol;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (local_time == TW'(cfg_round_len - 1'b1)) && (cfg_round_len != '0)
        |=> (local_time == '0)) else $error("wrap");                          // R1
    AST_SLOT_ZERO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (local_time == '0) |-> (slot_id == '0)) else $error("slot wrap");       // R2
    AST_GATE_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> rx_win) else $error("gate outside rx");                  // R4
    AST_TX_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> gate_open) else $error("tx outside gate");                   // R5
    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_line |-> gate_open) else $error("line outside gate");               // R6
    AST_VIOL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        viol_cnt >= $past(viol_cnt)) else $error("count dropped");             // R7
    AST_BABBLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        babble |=> babble) else $error("babble cleared");                      // R8

endmodule

// File: tb/tdma_slot_window_timer_tb_top.sv
`timescale 1ns/1ps
module tdma_slot_window_timer_tb_top;

    localparam int NS = 8, TW = 16, PW = 8, CW = 8;
    localparam int IW = 3, SCW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TW-1:0]  cfg_round_len = 16'd60;
    logic [PW-1:0]  cfg_prec = 8'd2;
    logic [SCW-1:0] cfg_nslots = 4'd3;
    logic           tbl_we = 1'b0;
    logic [IW-1:0]  tbl_idx = '0;
    logic [TW-1:0]  tbl_start = '0, tbl_dur = '0;
    logic           tbl_own = 1'b0;
    logic           tx_req = 1'b0;
    logic [TW-1:0]  local_time;
    logic [IW-1:0]  slot_id;
    logic           rx_win, gate_open, tx_en, tx_line, babble;
    logic [CW-1:0]  viol_cnt;

    int checks = 0, failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    tdma_slot_window_timer #(.NS(NS), .TW(TW), .PW(PW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_round_len(cfg_round_len),
        .cfg_prec(cfg_prec), .cfg_nslots(cfg_nslots), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_start(tbl_start), .tbl_dur(tbl_dur),
        .tbl_own(tbl_own), .tx_req(tx_req), .local_time(local_time),
        .slot_id(slot_id), .rx_win(rx_win), .gate_open(gate_open),
        .tx_en(tx_en), .tx_line(tx_line), .babble(babble), .viol_cnt(viol_cnt)
    );

    // behavioural reference
    int m_start [NS];
    int m_dur   [NS];
    bit m_own   [NS];
    int m_time = 0, m_slot = 0, m_viol = 0;
    bit m_rx = 0, m_gate = 0, m_tx = 0, m_line = 0, m_bab = 0;

    always @(posedge clk) begin
        int t, s, rel, d, p;
        bit g;
        if (!rst_n) begin
            m_time = 0; m_slot = 0; m_viol = 0;
            m_rx = 0; m_gate = 0; m_tx = 0; m_line = 0; m_bab = 0;
        end else begin
            t = (m_time + 1 >= int'(cfg_round_len)) ? 0 : m_time + 1;
            s = m_slot;
            if (t == 0) s = 0;
            else if (m_slot + 1 < int'(cfg_nslots) && t == m_start[m_slot + 1]) s = m_slot + 1;
            rel = t - m_start[s]; d = m_dur[s]; p = int'(cfg_prec);
            g = rel >= 0 && m_own[s] && rel >= p && rel < d + 3 * p;
            m_rx = rel >= 0 && rel < d + 4 * p;
            m_tx = rel >= 0 && m_own[s] && rel >= 2 * p && rel < 2 * p + d;
            if (tx_req && m_gate && !g) m_bab = 1;
            if (tx_req && !g && m_viol < 255) m_viol++;
            m_line = tx_req && g;
            m_gate = g; m_time = t; m_slot = s;
        end
        if (tbl_we) begin
            m_start[tbl_idx] = tbl_start; m_dur[tbl_idx] = tbl_dur; m_own[tbl_idx] = tbl_own;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", local_time, m_time, "local_time");
        chk("R2", slot_id, m_slot, "slot_id");
        chk("R3", rx_win, m_rx, "rx_win");
        chk("R4", gate_open, m_gate, "gate_open");
        chk("R5", tx_en, m_tx, "tx_en");
        chk("R6", tx_line, m_line, "tx_line");
        chk("R7", viol_cnt, m_viol, "viol_cnt");
        chk("R8", babble, m_bab, "babble");
    endtask

    task automatic run(int n, int mode);
        // mode 0: idle, 1: pulse inside transmit window, 2: continuous request
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            compare_all();
            tbl_we = 1'b0;
            case (mode)
                1: tx_req = (local_time >= 24 && local_time < 30);
                2: tx_req = 1'b1;
                default: tx_req = 1'b0;
            endcase
        end
    endtask

    task automatic wr(int idx, int st, int du, bit own);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_start = TW'(st);
        tbl_dur = TW'(du); tbl_own = own;
    endtask

    initial begin
        // R9: entries written while reset is held
        wr(0, 0, 6, 0);
        wr(1, 20, 8, 1);
        wr(2, 42, 5, 1);
        for (int k = 3; k < NS; k++) wr(k, 59, 1, 0);
        @(negedge clk);
        tbl_we = 1'b0;
        // R1 reset state
        chk("R1", local_time, 0, "reset time");
        chk("R1", {rx_win, gate_open, tx_en, tx_line, babble}, 0, "reset windows");
        chk("R1", viol_cnt, 0, "reset count");
        rst_n = 1'b1;
        run(130, 0);          // R2 R3 R4 R5: idle windows over two rounds
        run(130, 1);          // R6: request only inside transmit window
        chk("R8", babble, 0, "no babble after clean pulses");
        // R9: make slot 0 owned while running
        @(negedge clk);
        cyc++; compare_all();
        tbl_we = 1'b1; tbl_idx = 3'd0; tbl_start = 16'd0; tbl_dur = 16'd6; tbl_own = 1'b1;
        run(130, 0);
        run(700, 2);          // R6 R7 R8: babbling node, count saturates
        chk("R7", viol_cnt, 255, "saturated count");
        chk("R8", babble, 1, "babble set");
        run(60, 0);
        // R9: change precision and slot count
        cfg_prec = 8'd1;
        cfg_nslots = 4'd2;
        run(130, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule